// File: doc/BRIEF.md
# Parallel Bank-to-Decoder Permutation Crossbar

This block sits between a set of parallel memory banks and the same number of parallel soft-decision decoders. It lets all decoders read at once without any two of them asking the same bank for data. Every lane moves one word per cycle. In interleaved order, decoder lane `j` takes its word from bank lane `j XOR perm_sel`. The network that does this is built from log2(LANES) levels of 2:1 switches. Each level is steered by one bit of the control word, and that bit is shared by every switch in the level. In natural order the network passes data straight through.

The same block also produces the single read address that is sent to every bank. A local position counter advances when `step_en` is high and wraps at the sub-block length. In interleaved order the address is that position rotated right by `rot_amt` within the sub-block. Every sub-block therefore sees the same reordering. A parameter can add an output register on the data lanes, which cuts the combinational depth at the cost of one cycle of latency. The asynchronous active-low reset is released inside the block through a two-stage synchronizer.

Top module: `ibp_xbar`

## Requirements
- R1: While `rst_n` is low, and for the first two rising clock edges after it rises, `seq_pos` is 0 and `dec_data` is all zeros.
- R2: On each rising edge where `step_en` is 1, `seq_pos` advances by one modulo SUB_LEN. It goes from SUB_LEN-1 back to 0.
- R3: On a rising edge where `step_en` is 0, `seq_pos` keeps its value.
- R4: When `ilv_mode` is 0 (natural order), `rd_addr` equals `seq_pos`, and decoder lane `j` receives bank lane `j`.
- R5: When `ilv_mode` is 1 (interleaved order), `rd_addr` equals (`seq_pos` + `rot_amt`) mod SUB_LEN, for any `rot_amt` below SUB_LEN. All banks share this one address.
- R6: When `ilv_mode` is 1, decoder lane `j` receives bank lane `j XOR perm_sel`.
- R7: In every interleaved cycle, the LANES output lanes carry words taken from LANES distinct banks, so no bank is accessed twice.
- R8: Lane `i` occupies bits `[i*DW +: DW]` of both data buses. With REG_OUT=1, `dec_data` shows the routing of the `bank_data`, `perm_sel` and `ilv_mode` values present at the previous rising edge, and it does not change between edges.
- R9: In interleaved order, `perm_sel` = 0 gives the identity routing, and `perm_sel` with all bits set reverses the lane order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advance the local position counter |
| ilv_mode | input | 1 | 0 = natural order, 1 = interleaved order |
| perm_sel | input | log2(LANES) | Cross-block permutation control word |
| rot_amt | input | log2(SUB_LEN) | Right-rotation amount inside a sub-block |
| bank_data | input | LANES*DW | Words read from the banks, lane i in bits [i*DW +: DW] |
| dec_data | output | LANES*DW | Words delivered to the decoders, same packing |
| rd_addr | output | log2(SUB_LEN) | Read address shared by all banks |
| seq_pos | output | log2(SUB_LEN) | Current local position inside the sub-block |

## Verification
The bound checker runs on every cycle. It checks the counter step and hold, the shared address in both orders, the XOR routing of each lane (including the one-cycle register delay), and the zero state during reset. Some behaviours only the bench scenarios can show. One is that the outputs form a true permutation: the bench drives distinct words on each lane and checks that no bank word appears twice. The others are the identity and reversal patterns for the extreme control values, the counter wrap after a long run of steps, and the stable output between edges.

// File: rtl/ibp_pkg.sv
package ibp_pkg;

  typedef enum logic {
    ORDER_NATURAL     = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } order_e;

endpackage

// File: rtl/ibp_rst_sync.sv
module ibp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/ibp_switch_level.sv
module ibp_switch_level #(
  parameter int LANES  = 4,
  parameter int DW     = 8,
  parameter int STRIDE = 1
) (
  input  logic                  swap,
  input  logic [LANES*DW-1:0]   lanes_i,
  output logic [LANES*DW-1:0]   lanes_o
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int PEER = i ^ STRIDE;
    assign lanes_o[i*DW +: DW] = swap ? lanes_i[PEER*DW +: DW] : lanes_i[i*DW +: DW];
  end

endmodule

// File: rtl/ibp_butterfly.sv
module ibp_butterfly #(
  parameter int LANES = 4,
  parameter int DW    = 8,
  localparam int LG   = $clog2(LANES)
) (
  input  logic [LG-1:0]         ctl,
  input  logic [LANES*DW-1:0]   lanes_i,
  output logic [LANES*DW-1:0]   lanes_o
);

  logic [LANES*DW-1:0] stage [LG+1];

  assign stage[0] = lanes_i;

  for (genvar k = 0; k < LG; k++) begin : g_level
    ibp_switch_level #(
      .LANES  (LANES),
      .DW     (DW),
      .STRIDE (1 << k)
    ) u_level (
      .swap    (ctl[k]),
      .lanes_i (stage[k]),
      .lanes_o (stage[k+1])
    );
  end

  assign lanes_o = stage[LG];

endmodule

// File: rtl/ibp_rot_addr.sv
module ibp_rot_addr
  import ibp_pkg::*;
#(
  parameter int SUB_LEN = 128,
  localparam int AW     = $clog2(SUB_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  order_e        order,
  input  logic [AW-1:0] rot_amt,
  output logic [AW-1:0] seq_pos,
  output logic [AW-1:0] rd_addr
);

  localparam logic [AW-1:0] LAST   = AW'(SUB_LEN - 1);
  localparam logic [AW:0]   LEN_W  = (AW+1)'(SUB_LEN);

  logic [AW-1:0] seq_q;
  logic [AW-1:0] seq_d;
  logic [AW:0]   sum;

  always_comb begin
    seq_d = seq_q;
    if (step_en) begin
      seq_d = (seq_q == LAST) ? '0 : seq_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= '0;
    end else if (step_en) begin
      seq_q <= seq_d;
    end
  end

  always_comb begin
    sum = {1'b0, seq_q} + {1'b0, rot_amt};
    if (order == ORDER_INTERLEAVED) begin
      rd_addr = (sum >= LEN_W) ? AW'(sum - LEN_W) : AW'(sum);
    end else begin
      rd_addr = seq_q;
    end
  end

  assign seq_pos = seq_q;

endmodule

// File: rtl/ibp_xbar.sv
module ibp_xbar
  import ibp_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int DW      = 8,
  parameter int SUB_LEN = 128,
  parameter bit REG_OUT = 1'b1,
  localparam int LG     = $clog2(LANES),
  localparam int AW     = $clog2(SUB_LEN)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step_en,
  input  logic                  ilv_mode,
  input  logic [LG-1:0]         perm_sel,
  input  logic [AW-1:0]         rot_amt,
  input  logic [LANES*DW-1:0]   bank_data,
  output logic [LANES*DW-1:0]   dec_data,
  output logic [AW-1:0]         rd_addr,
  output logic [AW-1:0]         seq_pos
);

  order_e              order;
  logic                rst_int_n;
  logic [LG-1:0]       net_ctl;
  logic [LANES*DW-1:0] routed;

  assign order   = order_e'(ilv_mode);
  assign net_ctl = (order == ORDER_INTERLEAVED) ? perm_sel : '0;

  ibp_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  ibp_rot_addr #(
    .SUB_LEN (SUB_LEN)
  ) u_addr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .step_en (step_en),
    .order   (order),
    .rot_amt (rot_amt),
    .seq_pos (seq_pos),
    .rd_addr (rd_addr)
  );

  ibp_butterfly #(
    .LANES (LANES),
    .DW    (DW)
  ) u_net (
    .ctl     (net_ctl),
    .lanes_i (bank_data),
    .lanes_o (routed)
  );

  if (REG_OUT) begin : g_reg
    logic [LANES*DW-1:0] out_q;
    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) begin
        out_q <= '0;
      end else begin
        out_q <= routed;
      end
    end
    assign dec_data = out_q;
  end else begin : g_comb
    assign dec_data = routed;
  end

endmodule

// File: rtl/ibp_xbar_chk.sv
module ibp_xbar_chk #(
  parameter int LANES   = 4,
  parameter int DW      = 8,
  parameter int SUB_LEN = 128,
  parameter bit REG_OUT = 1'b1,
  localparam int LG     = $clog2(LANES),
  localparam int AW     = $clog2(SUB_LEN)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                step_en,
  input logic                ilv_mode,
  input logic [LG-1:0]       perm_sel,
  input logic [AW-1:0]       rot_amt,
  input logic [LANES*DW-1:0] bank_data,
  input logic [LANES*DW-1:0] dec_data,
  input logic [AW-1:0]       rd_addr,
  input logic [AW-1:0]       seq_pos
);

  logic [2:0]    live_q;
  logic          step_q;
  logic [AW-1:0] seq_q;
  logic          live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      step_q <= 1'b0;
      seq_q  <= '0;
    end else begin
      live_q <= {live_q[1:0], 1'b1};
      step_q <= step_en;
      seq_q  <= seq_pos;
    end
  end

  assign live = live_q[2];

  // R1
  reset_pos_chk: assert property (@(posedge clk) !rst_n |-> seq_pos == '0);

  // R1
  reset_data_chk: assert property (@(posedge clk) !rst_n |-> dec_data == '0);

  // R2
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && step_q |-> int'(seq_pos) == (int'(seq_q) + 1) % SUB_LEN);

  // R3
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && !step_q |-> seq_pos == seq_q);

  // R4
  addr_nat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ilv_mode |-> rd_addr == seq_pos);

  // R5
  addr_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ilv_mode |-> int'(rd_addr) == (int'(seq_pos) + int'(rot_amt)) % SUB_LEN);

  if (REG_OUT) begin : g_reg_chk
    logic [LANES*DW-1:0] bank_q;
    logic [LG-1:0]       perm_q;
    logic                mode_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q <= '0;
        perm_q <= '0;
        mode_q <= 1'b0;
      end else begin
        bank_q <= bank_data;
        perm_q <= perm_sel;
        mode_q <= ilv_mode;
      end
    end
    for (genvar j = 0; j < LANES; j++) begin : g_lane
      // R6
      route_ilv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live && mode_q |-> dec_data[j*DW +: DW] == bank_q[(int'(perm_q) ^ j)*DW +: DW]);
      // R4
      route_nat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live && !mode_q |-> dec_data[j*DW +: DW] == bank_q[j*DW +: DW]);
    end
  end else begin : g_comb_chk
    for (genvar j = 0; j < LANES; j++) begin : g_lane
      // R6
      route_ilv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live && ilv_mode |-> dec_data[j*DW +: DW] == bank_data[(int'(perm_sel) ^ j)*DW +: DW]);
      // R4
      route_nat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live && !ilv_mode |-> dec_data[j*DW +: DW] == bank_data[j*DW +: DW]);
    end
  end

endmodule

bind ibp_xbar ibp_xbar_chk #(
  .LANES   (LANES),
  .DW      (DW),
  .SUB_LEN (SUB_LEN),
  .REG_OUT (REG_OUT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step_en   (step_en),
  .ilv_mode  (ilv_mode),
  .perm_sel  (perm_sel),
  .rot_amt   (rot_amt),
  .bank_data (bank_data),
  .dec_data  (dec_data),
  .rd_addr   (rd_addr),
  .seq_pos   (seq_pos)
);

// File: tb/ibp_xbar_tb.sv
module ibp_xbar_tb;

  localparam int LANES   = 4;
  localparam int DW      = 8;
  localparam int SUB_LEN = 128;
  localparam int LG      = $clog2(LANES);
  localparam int AW      = $clog2(SUB_LEN);
  localparam int BW      = LANES * DW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          step_en;
  logic          ilv_mode;
  logic [LG-1:0] perm_sel;
  logic [AW-1:0] rot_amt;
  logic [BW-1:0] bank_data;
  logic [BW-1:0] dec_data;
  logic [AW-1:0] rd_addr;
  logic [AW-1:0] seq_pos;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;
  int mcnt     = 0;
  logic [BW-1:0] prev_exp = '0;

  always #2 clk = ~clk;

  ibp_xbar #(
    .LANES   (LANES),
    .DW      (DW),
    .SUB_LEN (SUB_LEN),
    .REG_OUT (1'b1)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .ilv_mode  (ilv_mode),
    .perm_sel  (perm_sel),
    .rot_amt   (rot_amt),
    .bank_data (bank_data),
    .dec_data  (dec_data),
    .rd_addr   (rd_addr),
    .seq_pos   (seq_pos)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] route(input logic [BW-1:0] d,
                                         input logic [LG-1:0] p, input bit ilv);
    logic [BW-1:0] r;
    for (int j = 0; j < LANES; j++) begin
      int src;
      src = ilv ? (j ^ int'(p)) : j;
      r[j*DW +: DW] = d[src*DW +: DW];
    end
    return r;
  endfunction

  function automatic int addr_model(input int cnt, input bit ilv, input int r);
    return ilv ? (cnt + r) % SUB_LEN : cnt;
  endfunction

  function automatic logic [BW-1:0] distinct_lanes();
    logic [BW-1:0] d;
    for (int j = 0; j < LANES; j++) begin
      d[j*DW +: DW] = DW'(($urandom() & 32'hFC) | 32'(j));
    end
    return d;
  endfunction

  function automatic bit all_distinct(input logic [BW-1:0] d);
    for (int a = 0; a < LANES; a++) begin
      for (int b = a + 1; b < LANES; b++) begin
        if (d[a*DW +: DW] == d[b*DW +: DW]) return 1'b0;
      end
    end
    return 1'b1;
  endfunction

  task automatic drive(input bit step, input bit ilv, input logic [LG-1:0] p,
                       input logic [AW-1:0] r, input logic [BW-1:0] d,
                       input string dtag, input bit chk_perm);
    logic [BW-1:0] exp;
    int ea;
    step_en   = step;
    ilv_mode  = ilv;
    perm_sel  = p;
    rot_amt   = r;
    bank_data = d;
    #1;
    ea = addr_model(mcnt, ilv, int'(r));
    chk(int'(rd_addr) == ea, ilv ? "R5" : "R4", 64'(rd_addr), 64'(ea));
    chk(dec_data == prev_exp, "R8", 64'(dec_data), 64'(prev_exp));
    exp = route(d, p, ilv);
    if (step) mcnt = (mcnt + 1) % SUB_LEN;
    @(negedge clk);
    chk(dec_data == exp, dtag, 64'(dec_data), 64'(exp));
    chk(int'(seq_pos) == mcnt, step ? "R2" : "R3", 64'(seq_pos), 64'(mcnt));
    if (chk_perm) chk(all_distinct(dec_data), "R7", 64'(dec_data), 64'(exp));
    prev_exp = exp;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1));
    rst_n     = 1'b0;
    step_en   = 1'b1;
    ilv_mode  = 1'b1;
    perm_sel  = '1;
    rot_amt   = AW'(5);
    bank_data = '1;
    repeat (3) @(negedge clk);
    // R1: reset holds state even with active inputs
    chk(seq_pos == '0, "R1", 64'(seq_pos), 64'd0);
    chk(dec_data == '0, "R1", 64'(dec_data), 64'd0);
    rst_n   = 1'b1;
    step_en = 1'b0;
    repeat (2) @(negedge clk);
    // R1: two synchronized edges still in reset
    chk(seq_pos == '0, "R1", 64'(seq_pos), 64'd0);
    chk(dec_data == '0, "R1", 64'(dec_data), 64'd0);

    // R4: natural order with distinct lanes
    drive(1'b0, 1'b0, LG'(2), AW'(9), distinct_lanes(), "R4", 1'b0);
    drive(1'b1, 1'b0, LG'(3), AW'(0), distinct_lanes(), "R4", 1'b0);
    // R9: identity and reversal control words
    drive(1'b1, 1'b1, '0, AW'(3), distinct_lanes(), "R9", 1'b1);
    begin
      logic [BW-1:0] d;
      logic [BW-1:0] rev;
      d = distinct_lanes();
      for (int j = 0; j < LANES; j++) rev[j*DW +: DW] = d[(LANES-1-j)*DW +: DW];
      drive(1'b0, 1'b1, '1, AW'(SUB_LEN-1), d, "R9", 1'b1);
      chk(dec_data == rev, "R9", 64'(dec_data), 64'(rev));
    end
    // R5: rotation wrapping past the sub-block end
    drive(1'b0, 1'b1, LG'(1), AW'(SUB_LEN-1), distinct_lanes(), "R6", 1'b1);

    // R2: long stepping run covering the wrap to 0
    for (int i = 0; i < SUB_LEN + 4; i++) begin
      drive(1'b1, 1'b0, LG'($urandom()), AW'($urandom()), distinct_lanes(), "R4", 1'b0);
    end

    // R6/R7: constrained random mix
    for (int i = 0; i < 500; i++) begin
      bit st;
      bit il;
      st = ($urandom() % 4) != 0;
      il = ($urandom() % 3) != 0;
      drive(st, il, LG'($urandom()), AW'($urandom()), distinct_lanes(),
            il ? "R6" : "R4", il);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule